// File: doc/BRIEF.md
# Timestamped Sample Capture Queue

This block is one capture channel of a multichannel converter front end. Each accepted 14-bit sample is stamped with the current value of a local 17-bit timer. The sample and its stamp are packed into one 32-bit word and stored in a four-entry first-in first-out queue. Software drains the queue through a one-cycle pop strobe, and the popped word appears on a registered read port. The current occupancy is visible at all times.

The channel watches the queue for four events: it became full, it became empty, a pop was attempted while it was empty, and a push was attempted while it was full. These events are latched in a sticky four-bit status word. Writing ones to the status word clears the selected bits. An enable mask selects which latched events reach the interrupt line. A mode input chooses the signalling path. In interrupt mode the masked status drives `irq`. In transfer mode, `dma_req` is raised while the queue holds data and `irq` stays low. A synchronous soft clear returns the pointers, level, status, timer and read port to their reset values.

Top module: `tsq_channel`

## Requirements
- R1: After reset, `fill_level` is 0, `evt_status` is 0, `pop_data` is 0, `tmr_value` is 0, and `irq` and `dma_req` are low.
- R2: The timer adds 1 on each clock edge at which `tmr_run` is 1. It holds its value when `tmr_run` is 0. `tmr_clr` forces it to 0 at the next edge, and this takes priority over counting.
- R3: A stored word carries the sample in bits [13:0]. Bits [30:14] hold the timer value in the capture cycle, which is the value shown on `tmr_value` before that edge. Bit 31 is 0.
- R4: Words are popped in the order they were pushed. `fill_level` counts from 0 to 4. `pop_data` shows the popped word in the cycle after the pop strobe and holds it until the next pop.
- R5: A push while the level is 4 is dropped and the stored words are unchanged. This sets status bit 3 (overflow). If a pop arrives in the same cycle, the pop is still served.
- R6: A pop while the level is 0 loads 0 into `pop_data`, leaves the level at 0 and sets status bit 2 (underflow).
- R7: Status bit 0 (full) is set only on the edge at which the level becomes 4. Status bit 1 (empty) is set only on the edge at which the level becomes 0. Staying at either level sets neither bit again.
- R8: If an event sets a status bit in the same cycle that `clr_wr` writes a 1 to that bit, the bit stays set.
- R9: When `clr_wr` is 1, each bit with a 1 in `clr_mask` reads 0 from the next cycle on. Bits with a 0 in the mask keep their value.
- R10: When `dma_mode` is 0, `irq` is 1 exactly when `evt_status & evt_en` is non-zero. When `dma_mode` is 1, `irq` is 0.
- R11: When `dma_mode` is 1, `dma_req` is 1 exactly when `fill_level` is non-zero. When `dma_mode` is 0, `dma_req` is 0.
- R12: `soft_clr` sets the level, status, timer and `pop_data` to 0 at the next edge. Events that occur in that cycle are not latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_clr | input | 1 | Synchronous clear of queue, status, timer and read port |
| tmr_run | input | 1 | Timer count enable |
| tmr_clr | input | 1 | Synchronous timer clear |
| tmr_value | output | 17 | Current timer value |
| smp_valid | input | 1 | Push strobe for a new sample |
| smp_data | input | 14 | Sample value |
| pop_req | input | 1 | Pop strobe |
| pop_data | output | 32 | Last popped word |
| fill_level | output | 3 | Queue occupancy, 0 to 4 |
| evt_en | input | 4 | Interrupt enable per event bit |
| clr_wr | input | 1 | Status clear strobe |
| clr_mask | input | 4 | Status bits to clear when `clr_wr` is 1 |
| evt_status | output | 4 | Sticky events: bit 3 overflow, bit 2 underflow, bit 1 empty, bit 0 full |
| dma_mode | input | 1 | 1 selects transfer requests, 0 selects interrupt |
| irq | output | 1 | Interrupt line |
| dma_req | output | 1 | Transfer request line |

## Verification
The hardest situation to reach is a status clear that collides with the event it is clearing. This needs a clear strobe in exactly the cycle in which the queue makes its transition to full. The bench reaches it by holding the queue at three entries. At one falling edge it then drives the fourth push together with `clr_wr` on the full bit, so both are seen at the same rising edge. The overflow-with-pop corner uses the same method: a push and a pop are driven in the same cycle on a full queue.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
   // Status bit positions; software decodes these, so they are fixed.
   localparam int EV_FULL  = 0;
   localparam int EV_EMPTY = 1;
   localparam int EV_UDF   = 2;
   localparam int EV_OVF   = 3;
   localparam int NUM_EV   = 4;

   typedef logic [NUM_EV-1:0] ev_vec_t;
endpackage

// File: rtl/tsq_timer.sv
module tsq_timer #(
   parameter int TMR_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_clr,
   input  logic             run,
   input  logic             clr,
   output logic [TMR_W-1:0] cnt
);
   if (TMR_W < 2) begin : g_bad_w
      $error("tsq_timer: TMR_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (soft_clr || clr) cnt <= '0;
      else if (run)             cnt <= cnt + TMR_W'(1);
   end

   // R2: a running, uncleared timer advances by exactly one
   a_r2_tmr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clr && !soft_clr) |=> (cnt == $past(cnt) + TMR_W'(1)));
   // R2: clear wins over run
   a_r2_tmr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
endmodule

// File: rtl/tsq_fifo.sv
module tsq_fifo
   import tsq_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int DEPTH  = 4,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_clr,
   input  logic              push,
   input  logic [WORD_W-1:0] push_word,
   input  logic              pop,
   output logic [WORD_W-1:0] pop_word,
   output logic [LVL_W-1:0]  level,
   output ev_vec_t           events
);
   if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
      $error("tsq_fifo: DEPTH must be a power of two, at least 2");
   end

   localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

   logic [WORD_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic              is_full, is_empty, push_ok, pop_ok;
   logic [LVL_W-1:0]  lvl_nxt;

   assign is_full  = (level == LVL_FULL);
   assign is_empty = (level == '0);
   // Acceptance is judged on the level at the start of the cycle.
   assign push_ok  = push && !is_full;
   assign pop_ok   = pop && !is_empty;
   assign lvl_nxt  = level + LVL_W'(push_ok) - LVL_W'(pop_ok);

   always_comb begin
      events           = '0;
      events[EV_FULL]  = (lvl_nxt == LVL_FULL) && !is_full;
      events[EV_EMPTY] = (lvl_nxt == '0) && !is_empty;
      events[EV_OVF]   = push && is_full;
      events[EV_UDF]   = pop && is_empty;
      if (soft_clr) events = '0;
   end

   always_ff @(posedge clk) begin
      if (push_ok && !soft_clr) mem[wr_ptr] <= push_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         level    <= '0;
         pop_word <= '0;
      end else if (soft_clr) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         level    <= '0;
         pop_word <= '0;
      end else begin
         level <= lvl_nxt;
         if (push_ok) wr_ptr <= wr_ptr + PTR_W'(1);
         if (pop_ok) begin
            rd_ptr   <= rd_ptr + PTR_W'(1);
            pop_word <= mem[rd_ptr];
         end else if (pop) begin
            pop_word <= '0;
         end
      end
   end

   // R4: occupancy never exceeds depth
   a_r4_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_FULL);
   // R5: a push on a full queue without a pop leaves it full
   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (is_full && push && !pop && !soft_clr) |=> (level == LVL_FULL));
   // R6: an empty pop returns zero and leaves the level at zero
   a_r6_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (is_empty && pop && !push) |=> (pop_word == '0 && level == '0));
endmodule

// File: rtl/tsq_events.sv
module tsq_events
   import tsq_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    soft_clr,
   input  ev_vec_t set,
   input  logic    clr_wr,
   input  ev_vec_t clr_mask,
   output ev_vec_t status
);
   ev_vec_t wipe;

   assign wipe = clr_wr ? clr_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        status <= '0;
      else if (soft_clr) status <= '0;
      else               status <= (status & ~wipe) | set;
   end

   // R8: a set always lands, even against a clear of the same bit
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set != '0 && !soft_clr) |=> ((status & $past(set)) == $past(set)));
   // R9: cleared bits without a concurrent set read zero next cycle
   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> ((status & $past(clr_mask & ~set)) == '0));
endmodule

// File: rtl/tsq_channel.sv
module tsq_channel
   import tsq_pkg::*;
#(
   parameter int SMP_W = 14,
   parameter int TS_W  = 18,
   parameter int TMR_W = 17,
   parameter int DEPTH = 4,
   localparam int WORD_W = SMP_W + TS_W,
   localparam int LVL_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_clr,
   input  logic              tmr_run,
   input  logic              tmr_clr,
   output logic [TMR_W-1:0]  tmr_value,
   input  logic              smp_valid,
   input  logic [SMP_W-1:0]  smp_data,
   input  logic              pop_req,
   output logic [WORD_W-1:0] pop_data,
   output logic [LVL_W-1:0]  fill_level,
   input  logic [NUM_EV-1:0] evt_en,
   input  logic              clr_wr,
   input  logic [NUM_EV-1:0] clr_mask,
   output logic [NUM_EV-1:0] evt_status,
   input  logic              dma_mode,
   output logic              irq,
   output logic              dma_req
);
   if (TMR_W > TS_W) begin : g_bad_stamp
      $error("tsq_channel: timer wider than stamp field");
   end

   logic [TS_W-1:0]   stamp;
   logic [WORD_W-1:0] word_in;
   ev_vec_t           ev_set;

   // Stamp field: direct when widths match, zero-extended otherwise.
   if (TMR_W == TS_W) begin : g_stamp_direct
      assign stamp = tmr_value;
   end else begin : g_stamp_ext
      assign stamp = {{(TS_W - TMR_W){1'b0}}, tmr_value};
   end

   assign word_in = {stamp, smp_data};

   tsq_timer #(.TMR_W(TMR_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_clr),
      .run      (tmr_run),
      .clr      (tmr_clr),
      .cnt      (tmr_value)
   );

   tsq_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_clr  (soft_clr),
      .push      (smp_valid),
      .push_word (word_in),
      .pop       (pop_req),
      .pop_word  (pop_data),
      .level     (fill_level),
      .events    (ev_set)
   );

   tsq_events u_events (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_clr),
      .set      (ev_set),
      .clr_wr   (clr_wr),
      .clr_mask (clr_mask),
      .status   (evt_status)
   );

   assign irq     = !dma_mode && ((evt_status & evt_en) != '0);
   assign dma_req = dma_mode && (fill_level != '0);

   // R11: transfer mode with data present always requests
   a_r11_dma_req: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_mode && fill_level != '0) |-> dma_req);
   // R12: soft clear empties the queue and status
   a_r12_soft_clr: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr |=> (fill_level == '0 && evt_status == '0 && tmr_value == '0));
endmodule

// File: tb/tsq_channel_tb.sv
module tsq_channel_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_clr = 0, tmr_run = 0, tmr_clr = 0;
   logic [16:0] tmr_value;
   logic        smp_valid = 0;
   logic [13:0] smp_data = '0;
   logic        pop_req = 0;
   logic [31:0] pop_data;
   logic [2:0]  fill_level;
   logic [3:0]  evt_en = '0, clr_mask = '0, evt_status;
   logic        clr_wr = 0, dma_mode = 0, irq, dma_req;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   tsq_channel u_dut (
      .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .tmr_run(tmr_run),
      .tmr_clr(tmr_clr), .tmr_value(tmr_value), .smp_valid(smp_valid),
      .smp_data(smp_data), .pop_req(pop_req), .pop_data(pop_data),
      .fill_level(fill_level), .evt_en(evt_en), .clr_wr(clr_wr),
      .clr_mask(clr_mask), .evt_status(evt_status), .dma_mode(dma_mode),
      .irq(irq), .dma_req(dma_req)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(); @(negedge clk); endtask

   task automatic push(input logic [13:0] d);
      smp_valid = 1; smp_data = d; cyc(); smp_valid = 0;
   endtask

   task automatic pop(); pop_req = 1; cyc(); pop_req = 0; endtask

   task automatic sclr(); soft_clr = 1; tmr_run = 0; cyc(); soft_clr = 0; endtask

   task automatic wclr(input logic [3:0] m);
      clr_wr = 1; clr_mask = m; cyc(); clr_wr = 0; clr_mask = '0;
   endtask

   task automatic t_reset();
      check("R1 level", 32'(fill_level), 0);
      check("R1 status", 32'(evt_status), 0);
      check("R1 pop_data", pop_data, 0);
      check("R1 timer", 32'(tmr_value), 0);
      check("R1 irq/dma", {30'b0, irq, dma_req}, 0);
   endtask

   task automatic t_timer();
      tmr_run = 1; repeat (5) cyc();
      check("R2 count", 32'(tmr_value), 5);
      tmr_run = 0; repeat (3) cyc();
      check("R2 hold", 32'(tmr_value), 5);
      tmr_run = 1; tmr_clr = 1; cyc(); tmr_clr = 0; tmr_run = 0;
      check("R2 clear priority", 32'(tmr_value), 0);
   endtask

   task automatic t_order();
      sclr();
      tmr_run = 1; repeat (7) cyc(); tmr_run = 0;
      for (int i = 0; i < 4; i++) begin
         if (i == 3) check("R7 no full before 4", 32'(evt_status[0]), 0);
         push(14'h1000 + 14'(i));
         check("R4 level up", 32'(fill_level), i + 1);
      end
      check("R7 full set", 32'(evt_status), 32'h1);
      wclr(4'b0001);
      cyc(); cyc();
      check("R7 full not re-set while full", 32'(evt_status), 0);
      for (int i = 0; i < 4; i++) begin
         pop();
         check("R3 R4 word order", pop_data, {1'b0, 17'd7, 14'h1000 + 14'(i)});
      end
      check("R4 level drained", 32'(fill_level), 0);
      check("R7 empty set", 32'(evt_status), 32'h2);
      cyc(); cyc();
      check("R3 pop_data holds", pop_data, {1'b0, 17'd7, 14'h1003});
   endtask

   task automatic t_stamp_live();
      sclr();
      tmr_run = 1; repeat (3) cyc();
      push(14'h3FFF);
      tmr_run = 0;
      pop();
      check("R3 stamp at capture", pop_data, {1'b0, 17'd3, 14'h3FFF});
   endtask

   task automatic t_overflow();
      sclr();
      for (int i = 0; i < 4; i++) push(14'(20 + i));
      push(14'd99);
      check("R5 level stays 4", 32'(fill_level), 4);
      check("R5 overflow bit", 32'(evt_status[3]), 1);
      smp_valid = 1; smp_data = 14'd77; pop_req = 1; cyc();
      smp_valid = 0; pop_req = 0;
      check("R5 pop served, push dropped", 32'(fill_level), 3);
      check("R5 first word", pop_data[13:0], 20);
      for (int i = 1; i < 4; i++) begin
         pop();
         check("R5 contents unchanged", pop_data[13:0], 20 + i);
      end
   endtask

   task automatic t_underflow();
      sclr();
      push(14'h55); pop();
      wclr(4'hF);
      check("R9 clear all", 32'(evt_status), 0);
      pop();
      check("R6 zero data", pop_data, 0);
      check("R6 level 0", 32'(fill_level), 0);
      check("R6 underflow only", 32'(evt_status), 32'h4);
   endtask

   task automatic t_collide();
      sclr();
      for (int i = 0; i < 3; i++) push(14'(i));
      smp_valid = 1; smp_data = 14'd3; clr_wr = 1; clr_mask = 4'b0001; cyc();
      smp_valid = 0; clr_wr = 0; clr_mask = '0;
      check("R8 set beats clear", 32'(evt_status[0]), 1);
      push(14'd9);
      check("R9 pre status", 32'(evt_status), 32'h9);
      wclr(4'b1000);
      check("R9 only masked bit cleared", 32'(evt_status), 32'h1);
      clr_wr = 0; clr_mask = 4'b0001; cyc(); clr_mask = '0;
      check("R9 mask ignored without strobe", 32'(evt_status), 32'h1);
   endtask

   task automatic t_irq();
      dma_mode = 0; evt_en = 4'b0000; cyc();
      check("R10 masked off", 32'(irq), 0);
      evt_en = 4'b0010; cyc();
      check("R10 other enable", 32'(irq), 0);
      evt_en = 4'b0001; cyc();
      check("R10 enabled bit", 32'(irq), 1);
      dma_mode = 1; cyc();
      check("R10 silent in dma mode", 32'(irq), 0);
      evt_en = '0; dma_mode = 0;
   endtask

   task automatic t_dma();
      sclr();
      dma_mode = 1; cyc();
      check("R11 empty no req", 32'(dma_req), 0);
      push(14'd1);
      check("R11 req with data", 32'(dma_req), 1);
      dma_mode = 0; cyc();
      check("R11 no req in irq mode", 32'(dma_req), 0);
   endtask

   task automatic t_soft();
      sclr();
      push(14'd5); push(14'd6); pop(); pop(); pop();
      push(14'd7);
      tmr_run = 1; repeat (4) cyc();
      check("R12 pre state", 32'(fill_level), 1);
      soft_clr = 1; pop_req = 1; cyc(); soft_clr = 0; pop_req = 0; tmr_run = 0;
      check("R12 level", 32'(fill_level), 0);
      check("R12 status", 32'(evt_status), 0);
      check("R12 timer", 32'(tmr_value), 0);
      check("R12 pop_data", pop_data, 0);
   endtask

   initial begin
      #(20 * 100000);
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) cyc();
      rst_n = 1;
      cyc();
      t_reset();
      t_timer();
      t_order();
      t_stamp_live();
      t_overflow();
      t_underflow();
      t_collide();
      t_irq();
      t_dma();
      t_soft();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule